// File: doc/BRIEF.md
# Dual-Output Sawtooth PWM Timer Channel

This block is a single timer channel that produces two pulse-width-modulated outputs from one shared 32-bit counter. The counter is clocked through a prescaler that divides the input clock by a power of four. It runs as a sawtooth between zero and a programmed period value. Each output has its own compare value, its own 5-bit waveform code and its own output enable. With the supported waveform code, an output goes high when counting starts and again at every period wrap. It toggles when the counter equals that output's compare value, so the compare value sets the duty.

Software reaches the channel through a word-aligned register bus. The bus has a write strobe, a byte address, write data and combinational read data. Software stops the counter, sets the operating mode and prescaler, and programs the period, compares and output control. It preloads the counter and then sets the start bit. The counter can also count downward. In that case it reloads the period when it passes zero.

Top module: `sawpwm_channel`

## Requirements
- R1: After a synchronous active-low reset, the control, period, compare, output-control and counter registers read 0, the direction register reads 0x1, and both outputs are low.
- R2: Registers sit at these byte addresses: control 0x2C, direction 0x30, output control 0x34, counter 0x48, compare A 0x4C, compare B 0x50, period 0x64. Control holds start in bit 0, mode in bits 18:16 and prescaler select in bits 26:24. Output control holds code A in bits 4:0, enable A in bit 8, code B in bits 20:16 and enable B in bit 24. Unused bits and unmapped addresses read 0.
- R3: The counter advances once every 4^n clocks, where n is the prescaler select. Select values 6 and 7 act as 5, which divides by 1024.
- R4: When direction bit 0 is 1, the counter counts up. On the prescaled tick where it is at or above the period value, it returns to 0, so a cycle lasts period+1 ticks.
- R5: With code 0x1B, an enabled output is high from the start of counting. It is set high at each wrap and toggles on a tick where the counter equals its compare value, with the wrap taking precedence. It is therefore high for compare+1 ticks of each cycle, and high for the whole cycle when compare is at or above the period.
- R6: An output is low whenever its enable bit is 0, its code is not 0x1B, the start bit is 0, or the mode field is nonzero. A nonzero mode also holds the counter.
- R7: A control write while the start bit is 1 updates only the start bit. The mode and prescaler fields keep their values.
- R8: A write to the counter address loads the counter, whether the counter is running or stopped. The load takes priority over a tick in the same cycle.
- R9: When direction bit 0 is 0, the counter counts down. On the tick where it is 0, it reloads the period value.
- R10: Clearing the start bit holds the counter value. Setting it again resumes counting from the held value with a fresh prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The hardest case is the exact alignment between prescaler phase, counter wrap and compare toggle for every combination of divider, period and compare. That includes compare values of 0, of the period itself and above it, where the wrap and the toggle land on the same tick. The bench starts the counter with a single control write, then counts clock cycles from that write. Every cycle it compares both outputs and the counter readback against a closed-form position, (cycles / 4^n) mod (period+1), over a sweep of dividers, periods and compare pairs. Stopping mid-cycle and restarting is driven the same way, so the held value and the fresh prescaler phase are visible through the counter readback.

// File: rtl/sawpwm_pkg.sv
// Shared constants for the sawtooth PWM channel: register byte offsets,
// the supported waveform code and the prescaler select limit.
package sawpwm_pkg;
    localparam logic [7:0] OFS_CTRL = 8'h2C;
    localparam logic [7:0] OFS_DIR  = 8'h30;
    localparam logic [7:0] OFS_IOC  = 8'h34;
    localparam logic [7:0] OFS_CNT  = 8'h48;
    localparam logic [7:0] OFS_CMPA = 8'h4C;
    localparam logic [7:0] OFS_CMPB = 8'h50;
    localparam logic [7:0] OFS_PER  = 8'h64;

    // Waveform: high at start, high at cycle end, toggle on compare match.
    localparam logic [4:0] WAVE_HI_END_TOGGLE = 5'h1B;

    localparam int PSEL_MAX = 5;
endpackage

// File: rtl/sawpwm_prescale.sv
// Prescaler: emits a one-cycle tick every 4^sel clocks while run is high.
// Assumes sel only changes while run is low; values above SEL_MAX saturate.
// The phase counter restarts from zero whenever run is low.
module sawpwm_prescale #(
    parameter int SEL_W   = 3,
    parameter int SEL_MAX = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PCW = 2 * SEL_MAX;

    logic [PCW-1:0] phase;
    logic [PCW-1:0] limit;
    int             eff_sel;

    // Saturate the select and derive the terminal phase value.
    always_comb begin
        eff_sel = (sel > SEL_W'(SEL_MAX)) ? SEL_MAX : int'(sel);
        limit   = PCW'((64'd1 << (2 * eff_sel)) - 64'd1);
    end

    // Phase counter: free-runs while running, cleared when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)               phase <= '0;
        else if (!run)            phase <= '0;
        else if (phase >= limit)  phase <= '0;
        else                      phase <= phase + 1'b1;
    end

    assign tick = run && (phase == limit);

    // R3
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (phase <= limit));
    // R3
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (phase == '0));
endmodule

// File: rtl/sawpwm_count.sv
// Shared sawtooth counter. It counts up and wraps to 0 when at or above
// the period, or counts down and reloads the period at 0. A bus load
// wins over a tick. wrap flags the tick that ends a cycle.
module sawpwm_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         up,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    assign wrap = tick && (up ? (cnt >= period) : (cnt == '0));

    // Counter state: load, wrap/reload, or single step per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (load)  cnt <= load_val;
        else if (tick) begin
            if (wrap)   cnt <= up ? '0 : period;
            else        cnt <= up ? cnt + 1'b1 : cnt - 1'b1;
        end
    end

    // R4
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && up && !load && (cnt < period)) |=> (cnt == $past(cnt) + 1'b1));
    // R4
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && up && !load && (cnt >= period)) |=> (cnt == '0));
    // R9
    down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !up && !load && (cnt == '0)) |=> (cnt == $past(period)));
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));
endmodule

// File: rtl/sawpwm_pin.sv
// One PWM output stage. It keeps a level that is set at restart and at
// each wrap and flips on a compare match. The pin is driven only while
// running, enabled and programmed with the supported waveform code.
module sawpwm_pin #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic         tick,
    input  logic         wrap,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic [4:0]   code,
    input  logic         oe,
    output logic         pin
);
    import sawpwm_pkg::*;

    logic level;

    // Output level: high on start and wrap, flipped on compare match.
    always_ff @(posedge clk) begin
        if (!rst_n)                level <= 1'b0;
        else if (restart)          level <= 1'b1;
        else if (tick) begin
            if (wrap)              level <= 1'b1;
            else if (cnt == cmp)   level <= ~level;
        end
    end

    assign pin = run && oe && (code == WAVE_HI_END_TOGGLE) && level;

    // R5
    wrap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wrap && !restart) |=> level);
    // R5
    match_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap && !restart && (cnt == cmp)) |=> (level != $past(level)));
    // R6
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !pin);
endmodule

// File: rtl/sawpwm_channel.sv
// Dual-output sawtooth PWM timer channel. Register file, shared
// prescaler and counter, and two output stages. Mode and prescaler
// writes are dropped while the start bit is set. Only mode 0 counts.
module sawpwm_channel #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int NPIN   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_a,
    output logic              pwm_b
);
    import sawpwm_pkg::*;

    logic             start_q;
    logic [2:0]       mode_q;
    logic [2:0]       psel_q;
    logic [1:0]       dir_q;
    logic [4:0]       wave_q [NPIN];
    logic             oe_q   [NPIN];
    logic [CNT_W-1:0] cmp_q  [NPIN];
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] cnt;
    logic             tick, wrap, run, restart;
    logic             wr_ctrl, wr_cnt;
    logic [NPIN-1:0]  pins;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_cnt  = bus_wr && (bus_addr == ADDR_W'(OFS_CNT));
    assign run     = start_q && (mode_q == 3'd0);
    assign restart = wr_ctrl && bus_wdata[0] && !start_q;

    // Control register: start always writable, mode/prescale only when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            mode_q  <= '0;
            psel_q  <= '0;
        end else if (wr_ctrl) begin
            start_q <= bus_wdata[0];
            if (!start_q) begin
                mode_q <= bus_wdata[18:16];
                psel_q <= bus_wdata[26:24];
            end
        end
    end

    // Direction, period, output-control and compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 2'b01;
            per_q <= '0;
            for (int i = 0; i < NPIN; i++) begin
                wave_q[i] <= '0;
                oe_q[i]   <= 1'b0;
                cmp_q[i]  <= '0;
            end
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFS_DIR)) dir_q <= bus_wdata[1:0];
            if (bus_addr == ADDR_W'(OFS_PER)) per_q <= bus_wdata[CNT_W-1:0];
            if (bus_addr == ADDR_W'(OFS_IOC)) begin
                for (int i = 0; i < NPIN; i++) begin
                    wave_q[i] <= bus_wdata[16*i +: 5];
                    oe_q[i]   <= bus_wdata[16*i + 8];
                end
            end
            if (bus_addr == ADDR_W'(OFS_CMPA)) cmp_q[0] <= bus_wdata[CNT_W-1:0];
            if (bus_addr == ADDR_W'(OFS_CMPB)) cmp_q[NPIN-1] <= bus_wdata[CNT_W-1:0];
        end
    end

    // Read mux: combinational view of the addressed register.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL): bus_rdata = DATA_W'({5'b0, psel_q, 5'b0, mode_q, 15'b0, start_q});
            ADDR_W'(OFS_DIR):  bus_rdata = DATA_W'(dir_q);
            ADDR_W'(OFS_IOC):  bus_rdata = DATA_W'({7'b0, oe_q[NPIN-1], 3'b0, wave_q[NPIN-1],
                                                    7'b0, oe_q[0], 3'b0, wave_q[0]});
            ADDR_W'(OFS_CNT):  bus_rdata = DATA_W'(cnt);
            ADDR_W'(OFS_CMPA): bus_rdata = DATA_W'(cmp_q[0]);
            ADDR_W'(OFS_CMPB): bus_rdata = DATA_W'(cmp_q[NPIN-1]);
            ADDR_W'(OFS_PER):  bus_rdata = DATA_W'(per_q);
            default:           bus_rdata = '0;
        endcase
    end

    sawpwm_prescale #(.SEL_W(3), .SEL_MAX(PSEL_MAX)) i_prescale (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(psel_q), .tick(tick)
    );

    sawpwm_count #(.W(CNT_W)) i_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .up(dir_q[0]),
        .load(wr_cnt), .load_val(bus_wdata[CNT_W-1:0]), .period(per_q),
        .cnt(cnt), .wrap(wrap)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        sawpwm_pin #(.W(CNT_W)) i_pin (
            .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
            .tick(tick), .wrap(wrap), .cnt(cnt), .cmp(cmp_q[g]),
            .code(wave_q[g]), .oe(oe_q[g]), .pin(pins[g])
        );
    end

    assign pwm_a = pins[0];
    assign pwm_b = pins[NPIN-1];

    // R7
    locked_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && start_q) |=> ((mode_q == $past(mode_q)) && (psel_q == $past(psel_q))));
    // R6
    stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!pwm_a && !pwm_b));
endmodule

// File: tb/test_sawpwm_channel.sv
module test_sawpwm_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_a, pwm_b;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    localparam logic [7:0] A_CTRL = 8'h2C, A_DIR = 8'h30, A_IOC = 8'h34,
        A_CNT = 8'h48, A_CMPA = 8'h4C, A_CMPB = 8'h50, A_PER = 8'h64;

    always #10 clk = ~clk;

    sawpwm_channel i_sawpwm_channel (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // Program a configuration, start it, and compare for ncyc cycles.
    task automatic run_cfg(input int n, input int per, input int ca, input int cb, input int ncyc);
        logic [31:0] v;
        int dv, k, p;
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'(n) << 24);
        wr(A_PER, 32'(per));
        wr(A_CMPA, 32'(ca));
        wr(A_CMPB, 32'(cb));
        wr(A_IOC, 32'h011B_011B);
        wr(A_CNT, 32'h0);
        wr(A_CTRL, (32'(n) << 24) | 32'h1);
        dv = 1 << (2 * (n > 5 ? 5 : n));
        for (int c = 0; c < ncyc; c++) begin
            k = c / dv;
            p = k % (per + 1);
            check("R5 pin A", 32'(pwm_a), 32'(p <= ca));
            check("R5 pin B", 32'(pwm_b), 32'(p <= cb));
            rd(A_CNT, v);
            check(n > 0 ? "R3 count" : "R4 count", v, 32'(p));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_DIR, v);  check("R1 dir", v, 1);
        rd(A_PER, v);  check("R1 period", v, 0);
        rd(A_CNT, v);  check("R1 counter", v, 0);
        rd(A_IOC, v);  check("R1 ioc", v, 0);
        check("R1 pins", {30'b0, pwm_a, pwm_b}, 0);

        // R2 register map and field placement
        wr(A_CTRL, 32'hFFFF_FFFE);
        rd(A_CTRL, v); check("R2 ctrl fields", v, 32'h0707_0000);
        wr(A_IOC, 32'hFFFF_FFFF);
        rd(A_IOC, v);  check("R2 ioc fields", v, 32'h011F_011F);
        wr(A_CMPB, 32'h1234_5678);
        rd(A_CMPB, v); check("R2 cmpB", v, 32'h1234_5678);
        rd(8'h40, v);  check("R2 unmapped", v, 0);
        wr(A_DIR, 32'h3);

        // R3/R4/R5 sweep: dividers, periods, compare pairs
        for (int n = 0; n < 3; n++) begin
            for (int pi = 0; pi < 3; pi++) begin
                int per;
                per = (pi == 0) ? 0 : (pi == 1 ? 3 : 6);
                run_cfg(n, per, 0, per + 1, 2 * (per + 1) * (1 << (2 * n)) + 2);
                run_cfg(n, per, per / 2, per, 2 * (per + 1) * (1 << (2 * n)) + 2);
            end
        end
        // R3 saturated select 7 behaves as 1024
        run_cfg(7, 5, 2, 9, 1025);

        // R7 mode/prescaler writes ignored while running
        run_cfg(0, 3, 1, 4, 4);
        wr(A_CTRL, 32'h0302_0001);
        rd(A_CTRL, v); check("R7 ctrl locked", v, 32'h1);
        rd(A_CNT, held);
        @(negedge clk);
        rd(A_CNT, v); check("R7 still counting at div 1", v, (held + 1) % 4);

        // R6 enable clear and unsupported code force low
        wr(A_IOC, 32'h0105_001B);
        for (int c = 0; c < 8; c++) begin
            check("R6 disabled A", 32'(pwm_a), 0);
            check("R6 bad code B", 32'(pwm_b), 0);
            @(negedge clk);
        end
        // R6 nonzero mode: no count, pins low
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h0001_0000);
        wr(A_IOC, 32'h011B_011B);
        wr(A_CTRL, 32'h0001_0001);
        rd(A_CNT, held);
        for (int c = 0; c < 4; c++) begin
            check("R6 mode pins", {30'b0, pwm_a, pwm_b}, 0);
            rd(A_CNT, v); check("R6 mode holds count", v, held);
            @(negedge clk);
        end

        // R10 stop holds, restart resumes
        run_cfg(0, 6, 3, 7, 3);
        wr(A_CTRL, 32'h0);
        rd(A_CNT, held);
        repeat (5) @(negedge clk);
        rd(A_CNT, v); check("R10 held", v, held);
        check("R10 stopped pins", {30'b0, pwm_a, pwm_b}, 0);
        wr(A_CTRL, 32'h1);
        check("R10 restart pin A high", 32'(pwm_a), 1);
        rd(A_CNT, v); check("R10 resume value", v, held);
        @(negedge clk);
        rd(A_CNT, v); check("R10 resume step", v, (held + 1) % 7);

        // R8 preload while stopped and while running
        wr(A_CTRL, 32'h0);
        wr(A_PER, 32'd5);
        wr(A_CNT, 32'd2);
        wr(A_CTRL, 32'h1);
        for (int c = 0; c < 8; c++) begin
            rd(A_CNT, v); check("R8 preload run", v, 32'((2 + c) % 6));
            @(negedge clk);
        end
        wr(A_CNT, 32'd0);
        rd(A_CNT, v); check("R8 load while running", v, 0);
        @(negedge clk);
        rd(A_CNT, v); check("R8 step after load", v, 1);

        // R9 down counting
        wr(A_CTRL, 32'h0);
        wr(A_DIR, 32'h0);
        wr(A_PER, 32'd3);
        wr(A_CNT, 32'd0);
        wr(A_CTRL, 32'h1);
        for (int c = 0; c < 10; c++) begin
            rd(A_CNT, v); check("R9 down count", v, 32'((4 - (c % 4)) % 4));
            @(negedge clk);
        end
        wr(A_CTRL, 32'h0);
        wr(A_DIR, 32'h3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule